// File: doc/BRIEF.md
# Transmit Byte FIFO with Lane Ordering

This block sits between a memory-side DMA engine and a byte-wide serializer on the transmit path. The DMA side writes a packet into a small array that is four bytes wide and eight entries deep. Each write is either a whole 32-bit long word or one 16-bit half. A byte reader walks each entry lane by lane, in little- or big-endian order, and hands bytes to the serializer over a valid/ready handshake. It marks the final byte of the packet with a last flag.

Packets need not start or end on an entry boundary. The start byte offset is latched when a packet opens, and the end byte offset is latched with the last write. The reader never presents the unused leading lanes of the first entry or the unused trailing lanes of the last entry. Streaming waits until the FIFO holds more bytes than a programmed threshold, or until the whole packet has been written. The block raises a refill request whenever occupancy is at or below that threshold. The request carries a burst length that follows either block sizing or empty-fill sizing.

Top module: `tx_byte_fifo`

## Requirements
- R1: Storage is DEPTH entries of four byte lanes. A 32-bit write (`cfg_wide`=1) fills one entry with `wr_data`. In 16-bit mode (`cfg_wide`=0), `wr_data[15:0]` fills one half of an entry. The first half of an entry is lanes 1:0 in little-endian mode and lanes 3:2 in big-endian mode, and the second write fills the other half. Bits 15:8 of the half go to the higher lane of the pair.
- R2: Within an entry, bytes leave in lane order 0,1,2,3 when `cfg_big`=0 and 3,2,1,0 when `cfg_big`=1, where lane n is `data[8n+7:8n]`.
- R3: Offsets count positions in output order (0..3). In the first entry, positions below `pkt_start_ofs` are never output. In the last entry, positions above `wr_end_ofs` are never output. `out_last` is high only on the byte at the end position. After that byte is taken, `out_valid` drops and the packet closes.
- R4: `out_valid` stays low until occupancy exceeds 2×`cfg_thr_words` bytes, or until the last write of the packet has been accepted. Occupancy means bytes written and not yet passed by the reader.
- R5: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_last` hold steady.
- R6: `dma_req` is high while a packet is open, its last write is not yet accepted, no burst is open, and occupancy is at or below the threshold. A cycle with `dma_req` and `dma_ack` both high opens a burst, and `dma_req` goes low the next cycle.
- R7: `dma_len` equals the free byte count when `cfg_empty_fill`=1. When `cfg_empty_fill`=0 it equals the smaller of the threshold bytes and the free byte count. A burst closes once that many bytes have been written or the last write is accepted.
- R8: `underrun` sets when streaming has begun, no complete entry is held, and the last write is not yet accepted. It stays set until the next `pkt_start`, which clears it.
- R9: After reset, `out_valid`, `dma_req` and `underrun` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wide | input | 1 | 1: 32-bit writes, 0: 16-bit writes |
| cfg_big | input | 1 | 1: big-endian lane order |
| cfg_empty_fill | input | 1 | 1: empty-fill burst sizing, 0: block sizing |
| cfg_thr_words | input | THR_W | Threshold in 16-bit words |
| pkt_start | input | 1 | Opens a packet (pulse) |
| pkt_start_ofs | input | 2 | First valid position in the first entry |
| wr_en | input | 1 | DMA write strobe |
| wr_data | input | 32 | DMA write data |
| wr_last | input | 1 | This write completes the last entry |
| wr_end_ofs | input | 2 | Last valid position in the last entry |
| dma_req | output | 1 | Refill request |
| dma_ack | input | 1 | Request granted |
| dma_len | output | CW+2 | Bytes to write for the current grant |
| out_valid | output | 1 | Byte available |
| out_ready | input | 1 | Serializer accepts the byte |
| out_data | output | 8 | Output byte |
| out_last | output | 1 | Final byte of the packet |
| underrun | output | 1 | Sticky starvation flag |

## Verification
The scoreboard drives unaligned starts and ends in both lane orders and both write widths. A reader that picked the wrong lane pointer or skipped the wrong positions would emit swapped or extra bytes, or drop bytes, and the queue comparison would catch each. The threshold edge is probed at exactly the threshold byte count. A design using at-or-above instead of strictly-above would start one write early, and one that ignored the last-write rule would hang on short packets. The refill test acknowledges a request, refills to just the threshold and then past it, and switches sizing mode. A wrong burst length, or a request that stayed up during an open burst or above threshold, shows up there. Draining mid-packet must raise a sticky underrun that only the next packet clears.

// File: rtl/tbf_pkg.sv
// Package: shared constants for the transmit byte FIFO.
// Assumes four byte lanes per entry; the lane count is not a parameter
// because the offset ports are two bits wide.
package tbf_pkg;
    localparam int LANES    = 4;
    localparam int LANE_W   = 8;
    localparam int ENTRY_W  = LANES * LANE_W;
endpackage

// File: rtl/tbf_store.sv
// Module: tbf_store
// Holds the entry array, the write pointer, the half-word assembly state and
// per-entry first/last tags. A write is dropped when all entries are full.
// Assumes DEPTH is a power of two so pointers wrap naturally.
module tbf_store #(
    parameter int DEPTH = 8,
    parameter int AW    = $clog2(DEPTH),
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wide,
    input  logic                        big,
    input  logic                        wr_en,
    input  logic [tbf_pkg::ENTRY_W-1:0] wr_data,
    input  logic                        wr_last,
    input  logic                        mark_first,
    input  logic                        pop,
    output logic [tbf_pkg::ENTRY_W-1:0] head_data,
    output logic                        head_first,
    output logic                        head_last,
    output logic [CW-1:0]               entries,
    output logic                        half_pend,
    output logic                        acc,
    output logic [2:0]                  acc_bytes,
    output logic                        completes
);
    import tbf_pkg::*;

    logic [ENTRY_W-1:0] mem     [DEPTH];
    logic               first_f [DEPTH];
    logic               last_f  [DEPTH];
    logic [AW-1:0]      wptr;
    logic [AW-1:0]      rptr;
    logic               h_sel;

    // Accept a write only when a free entry exists.
    assign acc       = wr_en && (entries != CW'(DEPTH));
    assign acc_bytes = wide ? 3'd4 : 3'd2;
    assign completes = acc && (wide || half_pend);
    // Upper half goes first in big-endian mode, lower half in little-endian.
    assign h_sel     = half_pend ^ big;

    assign head_data  = mem[rptr];
    assign head_first = first_f[rptr];
    assign head_last  = last_f[rptr];

    // Data array write: full entry or one half.
    always_ff @(posedge clk) begin
        if (acc) begin
            if (wide)
                mem[wptr] <= wr_data;
            else
                mem[wptr][{h_sel, 4'b0000} +: 16] <= wr_data[15:0];
        end
    end

    // Tag write when an entry becomes complete.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                first_f[i] <= 1'b0;
                last_f[i]  <= 1'b0;
            end
        end else if (completes) begin
            first_f[wptr] <= mark_first;
            last_f[wptr]  <= wr_last;
        end
    end

    // Pointer, half-assembly and entry-count bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr      <= '0;
            rptr      <= '0;
            half_pend <= 1'b0;
            entries   <= '0;
        end else begin
            if (completes) wptr <= wptr + AW'(1);
            if (pop)       rptr <= rptr + AW'(1);
            if (acc && !wide) half_pend <= ~half_pend;
            entries <= entries + CW'(completes) - CW'(pop);
        end
    end

    assert_no_overflow_R1: assert property (@(posedge clk) disable iff (!rst_n)
        entries <= CW'(DEPTH));

    assert_pop_nonempty_R2: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (entries != '0));
endmodule

// File: rtl/tbf_reader.sv
// Module: tbf_reader
// Byte-ordering reader: four constant lane pointers give the head entry's
// bytes in output order for each endianness; a position counter walks them,
// starting at the start offset in the first entry and stopping at the end
// offset in the last entry, so unused lanes are never presented.
// Assumes end_ofs >= start_ofs when one entry is both first and last.
module tbf_reader (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        big,
    input  logic [1:0]                  start_ofs,
    input  logic [1:0]                  end_ofs,
    input  logic                        head_avail,
    input  logic [tbf_pkg::ENTRY_W-1:0] head_data,
    input  logic                        head_first,
    input  logic                        head_last,
    input  logic                        stream_en,
    input  logic                        out_ready,
    output logic                        out_valid,
    output logic [7:0]                  out_data,
    output logic                        out_last,
    output logic                        pop,
    output logic [1:0]                  k_q
);
    import tbf_pkg::*;

    logic [7:0] ord_byte [LANES];
    logic [1:0] k_eff;
    logic       take;

    // One read pointer per output position, chosen by endianness.
    for (genvar j = 0; j < LANES; j++) begin : g_lane
        localparam int LE_LANE = j;
        localparam int BE_LANE = LANES - 1 - j;
        assign ord_byte[j] = big ? head_data[LANE_W*BE_LANE +: LANE_W]
                                 : head_data[LANE_W*LE_LANE +: LANE_W];
    end

    // Leading extraneous lanes are jumped over without a cycle.
    assign k_eff     = (head_first && (k_q < start_ofs)) ? start_ofs : k_q;
    assign out_valid = stream_en && head_avail;
    assign out_data  = ord_byte[k_eff];
    assign out_last  = head_last && (k_eff == end_ofs);
    assign take      = out_valid && out_ready;
    assign pop       = take && (out_last || (k_eff == 2'd3));

    // Position counter within the head entry.
    always_ff @(posedge clk) begin
        if (!rst_n)    k_q <= 2'd0;
        else if (pop)  k_q <= 2'd0;
        else if (take) k_q <= k_eff + 2'd1;
    end

    assert_hold_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=>
            (out_valid && $stable(out_data) && $stable(out_last)));

    assert_last_closes_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (take && out_last) |=> !out_valid);
endmodule

// File: rtl/tbf_dma.sv
// Module: tbf_dma
// Refill requester: asks for data while occupancy is at or below threshold,
// sizes each grant (block or empty-fill) and tracks the open burst.
// Assumes writes in the acknowledge cycle itself are not part of the burst.
module tbf_dma #(
    parameter int OW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          empty_fill,
    input  logic          in_pkt,
    input  logic          last_written,
    input  logic [OW-1:0] occ,
    input  logic [OW-1:0] free,
    input  logic [OW-1:0] thr_bytes,
    input  logic          dma_ack,
    input  logic          wr_acc,
    input  logic [2:0]    wr_bytes,
    input  logic          wr_last_acc,
    output logic          dma_req,
    output logic [OW-1:0] dma_len
);
    logic          busy;
    logic [OW-1:0] left;

    // Grant size: whole free space, or threshold capped by free space.
    assign dma_len = empty_fill ? free : ((thr_bytes < free) ? thr_bytes : free);
    assign dma_req = in_pkt && !last_written && !busy && (occ <= thr_bytes);

    // Burst open/close tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            left <= '0;
        end else if (!in_pkt) begin
            busy <= 1'b0;
        end else if (busy) begin
            if (wr_acc) begin
                if (wr_last_acc || (left <= OW'(wr_bytes))) busy <= 1'b0;
                else left <= left - OW'(wr_bytes);
            end
        end else if (dma_req && dma_ack && (dma_len != '0)) begin
            busy <= 1'b1;
            left <= dma_len;
        end
    end

    assert_ack_opens_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_req && dma_ack && (dma_len != '0)) |=> !dma_req);
endmodule

// File: rtl/tx_byte_fifo.sv
// Module: tx_byte_fifo (top)
// Transmit byte FIFO: DMA-side word writes in, ordered bytes out.
// Holds packet state (offsets, open/closed, streaming, underrun) and derives
// byte occupancy and free space for the reader and the refill requester.
// Assumes one packet at a time: pkt_start only after the previous one closed.
module tx_byte_fifo #(
    parameter int DEPTH = 8,
    parameter int THR_W = 4,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int OW   = CW + 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wide,
    input  logic             cfg_big,
    input  logic             cfg_empty_fill,
    input  logic [THR_W-1:0] cfg_thr_words,
    input  logic             pkt_start,
    input  logic [1:0]       pkt_start_ofs,
    input  logic             wr_en,
    input  logic [31:0]      wr_data,
    input  logic             wr_last,
    input  logic [1:0]       wr_end_ofs,
    output logic             dma_req,
    input  logic             dma_ack,
    output logic [OW-1:0]    dma_len,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [7:0]       out_data,
    output logic             out_last,
    output logic             underrun
);
    logic [31:0]   head_data;
    logic          head_first, head_last, half_pend;
    logic [CW-1:0] entries;
    logic          acc, completes, pop;
    logic [2:0]    acc_bytes;
    logic [1:0]    k_q;
    logic          in_pkt, first_pend, last_written, stream_on;
    logic [1:0]    start_q, end_q;
    logic [OW-1:0] occ, free, thr_bytes;
    logic          final_take;

    assign thr_bytes  = OW'({cfg_thr_words, 1'b0});
    assign occ        = {entries, 2'b00} + OW'({half_pend, 1'b0}) - OW'(k_q);
    assign free       = OW'(DEPTH * 4) - {entries, 2'b00} - OW'({half_pend, 1'b0});
    assign final_take = out_valid && out_ready && out_last;

    tbf_store #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .wide       (cfg_wide),
        .big        (cfg_big),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .wr_last    (wr_last),
        .mark_first (first_pend),
        .pop        (pop),
        .head_data  (head_data),
        .head_first (head_first),
        .head_last  (head_last),
        .entries    (entries),
        .half_pend  (half_pend),
        .acc        (acc),
        .acc_bytes  (acc_bytes),
        .completes  (completes)
    );

    tbf_reader u_reader (
        .clk        (clk),
        .rst_n      (rst_n),
        .big        (cfg_big),
        .start_ofs  (start_q),
        .end_ofs    (end_q),
        .head_avail (entries != '0),
        .head_data  (head_data),
        .head_first (head_first),
        .head_last  (head_last),
        .stream_en  (stream_on),
        .out_ready  (out_ready),
        .out_valid  (out_valid),
        .out_data   (out_data),
        .out_last   (out_last),
        .pop        (pop),
        .k_q        (k_q)
    );

    tbf_dma #(.OW(OW)) u_dma (
        .clk          (clk),
        .rst_n        (rst_n),
        .empty_fill   (cfg_empty_fill),
        .in_pkt       (in_pkt),
        .last_written (last_written),
        .occ          (occ),
        .free         (free),
        .thr_bytes    (thr_bytes),
        .dma_ack      (dma_ack),
        .wr_acc       (acc),
        .wr_bytes     (acc_bytes),
        .wr_last_acc  (acc && wr_last),
        .dma_req      (dma_req),
        .dma_len      (dma_len)
    );

    // Packet lifecycle: open, first-entry tag, last write, offsets.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_pkt       <= 1'b0;
            first_pend   <= 1'b0;
            last_written <= 1'b0;
            start_q      <= 2'd0;
            end_q        <= 2'd3;
        end else if (pkt_start) begin
            in_pkt       <= 1'b1;
            first_pend   <= 1'b1;
            last_written <= 1'b0;
            start_q      <= pkt_start_ofs;
        end else begin
            if (completes) first_pend <= 1'b0;
            if (acc && wr_last) begin
                last_written <= 1'b1;
                end_q        <= wr_end_ofs;
            end
            if (final_take) in_pkt <= 1'b0;
        end
    end

    // Streaming gate: above threshold or whole packet present.
    always_ff @(posedge clk) begin
        if (!rst_n || pkt_start)          stream_on <= 1'b0;
        else if (final_take)              stream_on <= 1'b0;
        else if (in_pkt && ((occ > thr_bytes) || last_written))
                                          stream_on <= 1'b1;
    end

    // Sticky starvation flag, cleared by the next packet.
    always_ff @(posedge clk) begin
        if (!rst_n || pkt_start) underrun <= 1'b0;
        else if (in_pkt && stream_on && (entries == '0) && !last_written)
                                 underrun <= 1'b1;
    end

    assert_underrun_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (underrun && !pkt_start) |=> underrun);
endmodule

// File: tb/sim_tx_byte_fifo.sv
`timescale 1ns/1ps
// Scoreboard bench: tasks queue expected bytes, a monitor compares output.
module sim_tx_byte_fifo;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wide = 1'b1, cfg_big = 1'b0, cfg_empty_fill = 1'b0;
    logic [3:0]  cfg_thr_words = 4'd2;
    logic        pkt_start = 1'b0;
    logic [1:0]  pkt_start_ofs = 2'd0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        wr_last = 1'b0;
    logic [1:0]  wr_end_ofs = 2'd3;
    logic        dma_req, dma_ack = 1'b0;
    logic [5:0]  dma_len;
    logic        out_valid, out_ready = 1'b0, out_last, underrun;
    logic [7:0]  out_data;

    int errors = 0;
    int checks = 0;
    bit done = 0;
    logic [8:0] exp_q[$];

    always #2.5 clk = ~clk;

    tx_byte_fifo u0 (
        .clk(clk), .rst_n(rst_n), .cfg_wide(cfg_wide), .cfg_big(cfg_big),
        .cfg_empty_fill(cfg_empty_fill), .cfg_thr_words(cfg_thr_words),
        .pkt_start(pkt_start), .pkt_start_ofs(pkt_start_ofs),
        .wr_en(wr_en), .wr_data(wr_data), .wr_last(wr_last), .wr_end_ofs(wr_end_ofs),
        .dma_req(dma_req), .dma_ack(dma_ack), .dma_len(dma_len),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_last(out_last), .underrun(underrun)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic push(input logic [7:0] b, input logic l);
        exp_q.push_back({l, b});
    endtask

    task automatic begin_pkt(input logic [1:0] ofs);
        @(posedge clk); #1 pkt_start = 1'b1; pkt_start_ofs = ofs;
        @(posedge clk); #1 pkt_start = 1'b0;
    endtask

    task automatic wr(input logic [31:0] d, input logic l, input logic [1:0] e);
        @(posedge clk); #1 wr_en = 1'b1; wr_data = d; wr_last = l; wr_end_ofs = e;
        @(posedge clk); #1 wr_en = 1'b0; wr_last = 1'b0;
    endtask

    task automatic drain();
        @(posedge clk); #1 out_ready = 1'b1;
        while (exp_q.size() != 0) @(negedge clk);
        @(posedge clk); #1 out_ready = 1'b0;
    endtask

    // Monitor: compare every accepted byte with the queue head.
    always @(negedge clk) begin
        if (rst_n && out_valid && out_ready) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R2 unexpected byte", out_data, 0);
            end else begin
                logic [8:0] e;
                e = exp_q.pop_front();
                chk(out_data == e[7:0], "R2/R3 byte", out_data, e[7:0]);
                chk(out_last == e[8],   "R3 last flag", out_last, e[8]);
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(out_valid == 1'b0, "R9 out_valid", out_valid, 0);
        chk(dma_req == 1'b0,   "R9 dma_req", dma_req, 0);
        chk(underrun == 1'b0,  "R9 underrun", underrun, 0);
        #1 rst_n = 1'b1;

        // 32-bit little-endian, aligned, threshold 4 bytes
        begin_pkt(2'd0);
        @(negedge clk);
        chk(dma_req == 1'b1, "R6 req at empty", dma_req, 1);
        chk(dma_len == 6'd4, "R7 block len", dma_len, 4);
        wr(32'h44332211, 1'b0, 2'd3);
        repeat (2) @(negedge clk);
        chk(out_valid == 1'b0, "R4 at threshold", out_valid, 0);
        wr(32'h88776655, 1'b0, 2'd3);
        repeat (2) @(negedge clk);
        chk(out_valid == 1'b1, "R4 above threshold", out_valid, 1);
        chk(out_data == 8'h11, "R2 first LE byte", out_data, 8'h11);
        @(negedge clk);
        chk(out_valid == 1'b1 && out_data == 8'h11, "R5 hold", out_data, 8'h11);
        for (int i = 1; i <= 8; i++) push(8'(i * 8'h11), 1'b0);
        wr(32'hCCBBAA99, 1'b1, 2'd3);
        push(8'h99, 0); push(8'hAA, 0); push(8'hBB, 0); push(8'hCC, 1);
        drain();
        @(negedge clk);
        chk(out_valid == 1'b0, "R3 closed after last", out_valid, 0);
        chk(dma_req == 1'b0,   "R6 no req when closed", dma_req, 0);

        // 32-bit big-endian, start 1, end 1
        cfg_big = 1'b1;
        begin_pkt(2'd1);
        wr(32'hA0A1A2A3, 1'b0, 2'd3);
        wr(32'hB0B1B2B3, 1'b1, 2'd1);
        push(8'hA1, 0); push(8'hA2, 0); push(8'hA3, 0); push(8'hB0, 0); push(8'hB1, 1);
        drain();

        // 16-bit little-endian, end 1
        cfg_big = 1'b0; cfg_wide = 1'b0;
        begin_pkt(2'd0);
        wr(32'h2211, 1'b0, 2'd3);
        wr(32'h4433, 1'b0, 2'd3);
        repeat (2) @(negedge clk);
        chk(out_valid == 1'b0, "R4 16-bit at threshold", out_valid, 0);
        wr(32'h6655, 1'b0, 2'd3);
        repeat (2) @(negedge clk);
        chk(out_valid == 1'b1 && out_data == 8'h11, "R1 lower half first LE", out_data, 8'h11);
        wr(32'h8877, 1'b1, 2'd1);
        push(8'h11, 0); push(8'h22, 0); push(8'h33, 0); push(8'h44, 0);
        push(8'h55, 0); push(8'h66, 1);
        drain();

        // 16-bit big-endian, start 2
        cfg_big = 1'b1;
        begin_pkt(2'd2);
        wr(32'hAABB, 1'b0, 2'd3);
        wr(32'hCCDD, 1'b0, 2'd3);
        wr(32'hEEFF, 1'b0, 2'd3);
        wr(32'h1122, 1'b1, 2'd3);
        push(8'hCC, 0); push(8'hDD, 0); push(8'hEE, 0); push(8'hFF, 0);
        push(8'h11, 0); push(8'h22, 1);
        drain();

        // Refill requests and burst sizing
        cfg_big = 1'b0; cfg_wide = 1'b1;
        begin_pkt(2'd0);
        @(posedge clk); #1 dma_ack = 1'b1;
        @(posedge clk); #1 dma_ack = 1'b0;
        @(negedge clk);
        chk(dma_req == 1'b0, "R6 req drops after ack", dma_req, 0);
        wr(32'h04030201, 1'b0, 2'd3);
        @(negedge clk);
        chk(dma_req == 1'b1, "R7 burst closed, req at threshold", dma_req, 1);
        wr(32'h08070605, 1'b0, 2'd3);
        @(negedge clk);
        chk(dma_req == 1'b0, "R6 no req above threshold", dma_req, 0);
        cfg_empty_fill = 1'b1;
        @(negedge clk);
        chk(dma_len == 6'd24, "R7 empty-fill len", dma_len, 24);
        cfg_empty_fill = 1'b0;
        wr(32'h0C0B0A09, 1'b1, 2'd3);
        for (int i = 1; i <= 12; i++) push(8'(i), i == 12);
        drain();

        // Underrun
        cfg_thr_words = 4'd1;
        begin_pkt(2'd0);
        wr(32'h04030201, 1'b0, 2'd3);
        push(8'h01, 0); push(8'h02, 0); push(8'h03, 0); push(8'h04, 0);
        drain();
        repeat (2) @(negedge clk);
        chk(underrun == 1'b1, "R8 underrun set", underrun, 1);
        chk(out_valid == 1'b0, "R8 no byte when starved", out_valid, 0);
        @(negedge clk);
        chk(underrun == 1'b1, "R8 underrun sticky", underrun, 1);
        wr(32'h000000E5, 1'b1, 2'd0);
        push(8'hE5, 1);
        drain();
        begin_pkt(2'd0);
        @(negedge clk);
        chk(underrun == 1'b0, "R8 cleared by new packet", underrun, 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(50000 * 5);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired, queue=%0d expected=0", exp_q.size());
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule